// File: doc/BRIEF.md
# LCD Common/Segment Role and Drive Level Selector

This block sits between the display-RAM readout and the analog output stage of a dot-matrix LCD driver with one bank of output pins. Every pin is either a segment (column) or a common (row). The split depends on whether the device is the timing master or a cascaded slave, and on a two-bit duty mode. On every row time the block picks one of six drive levels for each pin. It uses the current row index, the frame-alternation phase, the pixel bit for that pin, and the display-on and standby controls. The analog levels themselves are produced elsewhere. The block only emits a 3-bit level code per pin.

The block also works out the bias ratio that the level generator must use. The ratio either follows the duty mode or comes from an explicit 3-bit code. All results are registered, so the row sequencer sees them one clock after it presents the inputs. The asynchronous active-low reset is synchronised to the clock before it is released.

Top module: `comseg_drive_sel`

## Requirements
- R1: While reset is active, every pin code is 0 (ground) and the bias denominator output is 9.
- R2: As master, mode 00 makes pins 1–16 segments and pins 17–80 commons 1–64. Mode 10 makes pins 1–32 segments and pins 33–80 commons 1–48. Mode 11 makes pins 1–48 segments and pins 49–80 commons 1–32. The pixel bit of a common pin has no effect.
- R3: As master in mode 01, all 80 pins are commons 1–80 and no pin is a segment.
- R4: As slave, all 80 pins are segments in every mode. Pin p takes its pixel from pix_bits[p-1].
- R5: Level codes are 0 = ground, 1 = V1, 2 = V2, 3 = V3, 4 = V4, 5 = V5. A common whose number equals row_idx+1 is selected. It drives V1 when fr_phase is 0 and ground when fr_phase is 1. A non-selected common drives V5 when fr_phase is 0 and V2 when fr_phase is 1.
- R6: A segment whose pixel bit is 1 drives ground when fr_phase is 0 and V1 when fr_phase is 1. A segment whose pixel bit is 0 drives V3 when fr_phase is 0 and V4 when fr_phase is 1.
- R7: When disp_on is 0 or standby is 1, every pin code is 0, whatever the pixel bits, row and phase.
- R8: With bias_sel_en at 0, the bias denominator is 9, 9, 7 or 5 for modes 00, 01, 10 and 11.
- R9: With bias_sel_en at 1, bias codes 0–4 give denominators 5–9 in order, and codes 5–7 give 9.
- R10: The outputs change one clock after the inputs. A change applied between two rising edges does not show on the outputs before the next rising edge.
- R11: A row index at or beyond the number of commons selects no common, so every common pin takes its non-selected level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| is_master | input | 1 | 1 = timing master, 0 = cascaded slave |
| mode | input | 2 | Duty mode that sets the segment/common split |
| row_idx | input | 7 | Zero-based index of the current row time |
| fr_phase | input | 1 | Frame-alternation phase |
| pix_bits | input | 80 | Pixel bit per pin for the current row, bit p-1 for pin p |
| disp_on | input | 1 | Display enable |
| standby | input | 1 | Standby request that forces every pin to ground |
| bias_sel_en | input | 1 | 1 = bias taken from bias_code |
| bias_code | input | 3 | Explicit bias selection |
| lvl_bus | output | 240 | Level code per pin, bits 3p-1..3p-3 for pin p |
| bias_den | output | 4 | Resolved bias denominator (5 to 9) |

## Verification
The bench builds the block with its default parameters: 80 pins, segment counts of 16, 0, 32 and 48 for the four master modes, and a 7-bit row index. With these values each role boundary sits at a concrete pin. The bench checks the first and last common of every mode, and the selected common is walked through both phases. Because a 7-bit row index reaches past 80, the bench can also drive rows that exceed the common count of the 32- and 48-common modes. In those rows no common should be selected.

// File: rtl/comseg_pkg.sv
package comseg_pkg;
  typedef enum logic [2:0] {
    LV_GND = 3'd0,
    LV_V1  = 3'd1,
    LV_V2  = 3'd2,
    LV_V3  = 3'd3,
    LV_V4  = 3'd4,
    LV_V5  = 3'd5
  } lvl_e;

  localparam int LVL_W   = $bits(lvl_e);
  localparam int BIAS_LO = 5;
  localparam int BIAS_HI = 9;
endpackage

// File: rtl/comseg_role_map.sv
module comseg_role_map #(
  parameter int NUM_PINS = 80,
  parameter int ROW_W    = 7,
  parameter int SEG_M00  = 16,
  parameter int SEG_M01  = 0,
  parameter int SEG_M10  = 32,
  parameter int SEG_M11  = 48
) (
  input  logic                is_master,
  input  logic [1:0]          mode,
  input  logic [ROW_W-1:0]    row_idx,
  output logic [NUM_PINS-1:0] seg_mask,
  output logic [NUM_PINS-1:0] sel_mask
);
  int seg_cnt;

  always_comb begin
    if (!is_master) begin
      seg_cnt = NUM_PINS;
    end else begin
      case (mode)
        2'b00:   seg_cnt = SEG_M00;
        2'b01:   seg_cnt = SEG_M01;
        2'b10:   seg_cnt = SEG_M10;
        default: seg_cnt = SEG_M11;
      endcase
    end
  end

  // Pins below the boundary are segments; above it, pin p carries common p-seg_cnt.
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign seg_mask[p] = (p < seg_cnt);
    assign sel_mask[p] = !seg_mask[p] && (int'(row_idx) == (p - seg_cnt));
  end
endmodule

// File: rtl/comseg_bias_res.sv
module comseg_bias_res
  import comseg_pkg::*;
#(
  parameter int BIAS_W = 4,
  parameter int CODE_W = 3
) (
  input  logic [1:0]        mode,
  input  logic              bias_sel_en,
  input  logic [CODE_W-1:0] bias_code,
  output logic [BIAS_W-1:0] bias_den
);
  localparam int SPAN = BIAS_HI - BIAS_LO;

  always_comb begin
    if (bias_sel_en) begin
      if (int'(bias_code) <= SPAN) bias_den = BIAS_W'(BIAS_LO + int'(bias_code));
      else                         bias_den = BIAS_W'(BIAS_HI);
    end else begin
      case (mode)
        2'b10:   bias_den = BIAS_W'(7);
        2'b11:   bias_den = BIAS_W'(5);
        default: bias_den = BIAS_W'(BIAS_HI);
      endcase
    end
  end
endmodule

// File: rtl/comseg_level_pick.sv
module comseg_level_pick
  import comseg_pkg::*;
(
  input  logic is_seg,
  input  logic is_sel,
  input  logic pix,
  input  logic phase,
  input  logic blank,
  output lvl_e lvl
);
  always_comb begin
    if (blank) begin
      lvl = LV_GND;
    end else if (is_seg) begin
      if (pix) lvl = phase ? LV_V1 : LV_GND;
      else     lvl = phase ? LV_V4 : LV_V3;
    end else begin
      if (is_sel) lvl = phase ? LV_GND : LV_V1;
      else        lvl = phase ? LV_V2  : LV_V5;
    end
  end
endmodule

// File: rtl/comseg_drive_sel.sv
module comseg_drive_sel
  import comseg_pkg::*;
#(
  parameter int NUM_PINS = 80,
  parameter int ROW_W    = 7,
  parameter int CODE_W   = 3,
  parameter int BIAS_W   = 4,
  parameter int SEG_M00  = 16,
  parameter int SEG_M01  = 0,
  parameter int SEG_M10  = 32,
  parameter int SEG_M11  = 48
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        is_master,
  input  logic [1:0]                  mode,
  input  logic [ROW_W-1:0]            row_idx,
  input  logic                        fr_phase,
  input  logic [NUM_PINS-1:0]         pix_bits,
  input  logic                        disp_on,
  input  logic                        standby,
  input  logic                        bias_sel_en,
  input  logic [CODE_W-1:0]           bias_code,
  output logic [NUM_PINS*LVL_W-1:0]   lvl_bus,
  output logic [BIAS_W-1:0]           bias_den
);
  localparam logic [BIAS_W-1:0] BIAS_RST = BIAS_W'(BIAS_HI);

  logic rst_meta, rst_s_n;
  logic [NUM_PINS-1:0] seg_mask, sel_mask;
  logic blank;
  logic [NUM_PINS-1:0][LVL_W-1:0] lvl_d, lvl_q;
  logic [BIAS_W-1:0] bias_d, bias_q;

  // Reset asserts at once and releases on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s_n  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s_n  <= rst_meta;
    end
  end

  comseg_role_map #(
    .NUM_PINS(NUM_PINS), .ROW_W(ROW_W),
    .SEG_M00(SEG_M00), .SEG_M01(SEG_M01), .SEG_M10(SEG_M10), .SEG_M11(SEG_M11)
  ) u_role (
    .is_master(is_master), .mode(mode), .row_idx(row_idx),
    .seg_mask(seg_mask), .sel_mask(sel_mask)
  );

  comseg_bias_res #(.BIAS_W(BIAS_W), .CODE_W(CODE_W)) u_bias (
    .mode(mode), .bias_sel_en(bias_sel_en), .bias_code(bias_code), .bias_den(bias_d)
  );

  assign blank = !disp_on || standby;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_lvl
    lvl_e pick;
    comseg_level_pick u_pick (
      .is_seg(seg_mask[p]), .is_sel(sel_mask[p]), .pix(pix_bits[p]),
      .phase(fr_phase), .blank(blank), .lvl(pick)
    );
    assign lvl_d[p] = pick;

    // R6 and R5: segments never take common-only levels, commons never take segment-only ones.
    assert_seg_levels_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
      seg_mask[p] |=> (lvl_q[p] != LVL_W'(LV_V2) && lvl_q[p] != LVL_W'(LV_V5)));
    assert_com_levels_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
      !seg_mask[p] |=> (lvl_q[p] != LVL_W'(LV_V3) && lvl_q[p] != LVL_W'(LV_V4)));
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      lvl_q  <= '0;
      bias_q <= BIAS_RST;
    end else begin
      lvl_q  <= lvl_d;
      bias_q <= bias_d;
    end
  end

  assign lvl_bus  = lvl_q;
  assign bias_den = bias_q;

  assert_blank_gnd_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    blank |=> (lvl_bus == '0));
  assert_slave_all_seg_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    !is_master |-> (seg_mask == '1));
  assert_full_com_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (is_master && mode == 2'b01) |-> (seg_mask == '0));
  assert_one_common_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0(sel_mask));
  assert_bias_range_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bias_q >= BIAS_W'(BIAS_LO) && bias_q <= BIAS_W'(BIAS_HI)));
endmodule

// File: tb/comseg_drive_sel_tb.sv
module comseg_drive_sel_tb;
  localparam int NP = 80;
  localparam int RW = 7;
  localparam int LW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic is_master;
  logic [1:0] mode;
  logic [RW-1:0] row_idx;
  logic fr_phase;
  logic [NP-1:0] pix_bits;
  logic disp_on, standby, bias_sel_en;
  logic [2:0] bias_code;
  logic [NP*LW-1:0] lvl_bus;
  logic [3:0] bias_den;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  comseg_drive_sel u_dut (
    .clk(clk), .rst_n(rst_n), .is_master(is_master), .mode(mode), .row_idx(row_idx),
    .fr_phase(fr_phase), .pix_bits(pix_bits), .disp_on(disp_on), .standby(standby),
    .bias_sel_en(bias_sel_en), .bias_code(bias_code), .lvl_bus(lvl_bus), .bias_den(bias_den)
  );

  // Segment count per role and mode, from R2, R3, R4.
  function automatic int seg_count(logic m, logic [1:0] md);
    if (!m) return NP;
    case (md)
      2'b00: return 16;
      2'b01: return 0;
      2'b10: return 32;
      default: return 48;
    endcase
  endfunction

  function automatic logic [NP*LW-1:0] build_exp();
    logic [NP*LW-1:0] v;
    int sc;
    logic [2:0] c;
    sc = seg_count(is_master, mode);
    for (int p = 0; p < NP; p++) begin
      if (!disp_on || standby) c = 3'd0;                           // R7
      else if (p < sc) c = pix_bits[p] ? (fr_phase ? 3'd1 : 3'd0)  // R6
                                       : (fr_phase ? 3'd4 : 3'd3);
      else if (p - sc == int'(row_idx)) c = fr_phase ? 3'd0 : 3'd1; // R5
      else c = fr_phase ? 3'd2 : 3'd5;                             // R5, R11
      v[p*LW +: LW] = c;
    end
    return v;
  endfunction

  task automatic cmp_bus(input logic [NP*LW-1:0] exp_v, input string req);
    checks++;
    for (int p = 0; p < NP; p++) begin
      if (lvl_bus[p*LW +: LW] !== exp_v[p*LW +: LW]) begin
        fails++;
        $display("FAIL %s pin %0d actual=%0d expected=%0d", req, p + 1,
                 lvl_bus[p*LW +: LW], exp_v[p*LW +: LW]);
        break;
      end
    end
  endtask

  task automatic cmp_bias(input logic [3:0] exp_b, input string req);
    checks++;
    if (bias_den !== exp_b) begin
      fails++;
      $display("FAIL %s bias actual=%0d expected=%0d", req, bias_den, exp_b);
    end
  endtask

  task automatic drive(input logic m, input logic [1:0] md, input int row, input logic ph,
                       input logic [NP-1:0] px);
    @(negedge clk);
    is_master = m; mode = md; row_idx = RW'(row); fr_phase = ph; pix_bits = px;
    @(negedge clk);
  endtask

  task automatic t_reset_R1;
    rst_n = 1'b0; is_master = 1'b1; mode = 2'b11; row_idx = '0; fr_phase = 1'b1;
    pix_bits = '1; disp_on = 1'b1; standby = 1'b0; bias_sel_en = 1'b1; bias_code = 3'd0;
    repeat (3) @(negedge clk);
    cmp_bus('0, "R1");
    cmp_bias(4'd9, "R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_master_split_R2;
    logic [NP-1:0] px = {5{16'hC3A5}};
    drive(1'b1, 2'b00, 0, 1'b0, px);  cmp_bus(build_exp(), "R2 m00 first common");
    drive(1'b1, 2'b00, 63, 1'b1, px); cmp_bus(build_exp(), "R2 m00 last common");
    drive(1'b1, 2'b10, 0, 1'b1, ~px); cmp_bus(build_exp(), "R2 m10");
    drive(1'b1, 2'b10, 47, 1'b0, px); cmp_bus(build_exp(), "R2 m10 last common");
    drive(1'b1, 2'b11, 31, 1'b0, px); cmp_bus(build_exp(), "R2 m11");
    drive(1'b1, 2'b11, 5, 1'b0, '1);  cmp_bus(build_exp(), "R2 common ignores pixel");
  endtask

  task automatic t_all_common_R3;
    drive(1'b1, 2'b01, 0, 1'b0, '1);  cmp_bus(build_exp(), "R3 row0");
    drive(1'b1, 2'b01, 79, 1'b1, '0); cmp_bus(build_exp(), "R3 row79");
  endtask

  task automatic t_slave_R4;
    for (int md = 0; md < 4; md++) begin
      drive(1'b0, 2'(md), md * 7, 1'(md), {20{4'h9}} ^ NP'(md));
      cmp_bus(build_exp(), "R4 slave");
    end
  endtask

  task automatic t_levels_R5_R6;
    // R5/R6: all four phase/pixel combinations on mode 00.
    drive(1'b1, 2'b00, 10, 1'b0, {40{2'b10}}); cmp_bus(build_exp(), "R5 R6 phase0");
    drive(1'b1, 2'b00, 10, 1'b1, {40{2'b10}}); cmp_bus(build_exp(), "R5 R6 phase1");
  endtask

  task automatic t_blank_R7;
    disp_on = 1'b0;
    drive(1'b1, 2'b00, 3, 1'b0, '1); cmp_bus('0, "R7 display off");
    drive(1'b0, 2'b10, 3, 1'b1, '0); cmp_bus('0, "R7 display off slave");
    disp_on = 1'b1; standby = 1'b1;
    drive(1'b1, 2'b01, 0, 1'b0, '1); cmp_bus('0, "R7 standby");
    standby = 1'b0;
    drive(1'b1, 2'b01, 0, 1'b0, '1); cmp_bus(build_exp(), "R7 restored");
  endtask

  task automatic t_bias_R8_R9;
    logic [3:0] auto_tab [4] = '{4'd9, 4'd9, 4'd7, 4'd5};
    bias_sel_en = 1'b0;
    for (int md = 0; md < 4; md++) begin
      drive(1'b1, 2'(md), 0, 1'b0, '0);
      cmp_bias(auto_tab[md], "R8");
    end
    bias_sel_en = 1'b1;
    for (int c = 0; c < 8; c++) begin
      bias_code = 3'(c);
      drive(1'b1, 2'b11, 0, 1'b0, '0);
      cmp_bias((c <= 4) ? 4'(5 + c) : 4'd9, "R9");
    end
  endtask

  task automatic t_latency_R10;
    logic [NP*LW-1:0] old_v;
    drive(1'b1, 2'b00, 2, 1'b0, '0);
    old_v = build_exp();
    @(negedge clk);
    fr_phase = 1'b1; pix_bits = '1;
    #3;
    cmp_bus(old_v, "R10 before edge");
    @(negedge clk);
    cmp_bus(build_exp(), "R10 after edge");
  endtask

  task automatic t_row_beyond_R11;
    drive(1'b1, 2'b11, 40, 1'b0, '0);  cmp_bus(build_exp(), "R11 m11 row40");
    drive(1'b1, 2'b10, 127, 1'b1, '1); cmp_bus(build_exp(), "R11 m10 row127");
  endtask

  initial begin
    t_reset_R1();
    t_master_split_R2();
    t_all_common_R3();
    t_slave_R4();
    t_levels_R5_R6();
    t_blank_R7();
    t_bias_R8_R9();
    t_latency_R10();
    t_row_beyond_R11();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule